// File: doc/BRIEF.md
# Legacy Memory Window Router

This block sits beside the CPU memory path and classifies every access that lands in the 640 KB to 1 MB legacy region. Each access is sent to one of three places. It can go to local DRAM, or be forwarded to the legacy expansion bus, or, if it is a write to a segment marked read-only, be dropped without effect. The region is split into fourteen segments. Each segment carries a 2-bit attribute, and these attributes are packed two to a byte in a small byte-addressed configuration space.

A programmable system-management RAM window can claim part of the region for DRAM regardless of segment attributes. The window opens in two cases: when its mode-gated enable is set and the system-management mode input is high, or whenever its unconditional open bit is set. It is honoured only when it lies wholly inside the legacy region. Configuration writes act directly on routing, with no separate commit step. The decision for an access sampled at a clock edge appears on the registered route outputs right after that edge.

Top module: `legacy_window_router`

## Requirements
- R1: The region 0xA0000-0xFFFFF is split into 14 segments. Segment 0 is 0xA0000-0xBFFFF. Segments 1 to 12 are 16 KB each, starting at 0xC0000 + (n-1)*0x4000. Segment 13 is 0xF0000-0xFFFFF. The attribute of segment i is bits [1:0] (i even) or bits [5:4] (i odd) of configuration byte 0x61 + (i>>1). The other bits of that byte are stored and read back but do not affect routing.
- R2: Attribute 3 sends both reads and writes to DRAM (`rt_dram`=1).
- R3: With attribute 2, reads go to DRAM. Writes assert `rt_wr_drop` only. When `rt_valid` is 1, exactly one of `rt_dram`, `rt_legacy` and `rt_wr_drop` is 1; when `rt_valid` is 0, all three are 0.
- R4: Attributes 0 and 1 forward reads and writes to the legacy bus (`rt_legacy`=1).
- R5: Any address below 0xA0000 or at or above 0x100000 routes to DRAM, whatever the attributes.
- R6: The 32-bit SMRAM control word occupies configuration bytes 0x6C (bits 7:0) to 0x6F (bits 31:24). Its reset value is 0x0000000A. The attribute bytes 0x61-0x67 reset to 0x00.
- R7: The window is open when bit 31 is set and the system-management input is high, or when bit 26 is set, whatever the mode.
- R8: The window base is bits 15:0 of the control word shifted left by 16. Its size is (bits 23:20 + 1) * 64 KB. Any access inside an open, valid window goes to DRAM, overriding the segment attribute; this includes writes to read-only segments.
- R9: A window with base below 0xA0000, or with base + size above 0x100000, is ignored.
- R10: A configuration write takes effect for an access sampled at the next clock edge or later. Offsets other than 0x61-0x67 and 0x6C-0x6F read as 0x00 and ignore writes. Configuration reads are combinational.
- R11: The route outputs are registered. An access sampled with `acc_valid` at an edge shows `rt_valid`=1 after that edge, and `rt_valid` is 0 after an edge with no access. A change on `smm_mode` is captured at the next edge and affects only accesses sampled after that edge.
- R12: `rst_n` clears all state asynchronously. Its release is synchronised through two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | CFG_AW | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| smm_mode | input | 1 | System-management mode indication |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | ADDR_W | Access byte address |
| acc_write | input | 1 | 1 = write, 0 = read |
| rt_valid | output | 1 | Route decision present |
| rt_dram | output | 1 | Access goes to DRAM |
| rt_legacy | output | 1 | Access forwarded to legacy bus |
| rt_wr_drop | output | 1 | Write suppressed and discarded |

## Verification
The attribute sweep rotates all four attribute values across every segment in four patterns. It probes each segment's first and last byte with reads and writes, which separates nibble placement and segment boundaries from the value decode. Junk in the unused attribute bits shows that those bits do not reach routing. The window sweep walks bases 0x8 to 0x10 and several sizes under four combinations of mode and enable, and probes just outside and just inside each window edge. This separates the open and valid conditions and the override of read-only segments. Addresses just outside the region, full-byte readback over all 256 offsets, and an access driven on the same edge as a mode change pin down the decode limits, the unmapped offsets, and when the mode input takes effect.

// File: rtl/lwr_pkg.sv
package lwr_pkg;
  localparam int NSEG      = 14;
  localparam int SEG_W     = 4;
  localparam int NATTR     = (NSEG + 1) / 2;
  localparam int NSMR      = 4;
  localparam int ATTR_BASE = 'h61;
  localparam int SMR_BASE  = 'h6C;
  localparam logic [31:0] SMR_RESET = 32'h0000_000A;
  localparam logic [32:0] WIN_LO    = 33'h0_000A_0000;
  localparam logic [32:0] WIN_HI    = 33'h0_0010_0000;
  localparam logic [32:0] MID_LO    = 33'h0_000C_0000;
  localparam logic [32:0] TOP_LO    = 33'h0_000F_0000;

  typedef enum logic [1:0] {
    ATTR_BUS0 = 2'd0,
    ATTR_BUS1 = 2'd1,
    ATTR_RO   = 2'd2,
    ATTR_RW   = 2'd3
  } attr_e;
endpackage

// File: rtl/lwr_cfg_regs.sv
module lwr_cfg_regs
  import lwr_pkg::*;
#(
  parameter int CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic [2*NSEG-1:0] attr_vec,
  output logic [31:0]       smram
);
  logic [7:0] attr_q [NATTR];
  logic [7:0] attr_d [NATTR];
  logic [7:0] smr_q  [NSMR];
  logic [7:0] smr_d  [NSMR];

  // next state
  always_comb begin
    for (int k = 0; k < NATTR; k++) begin
      attr_d[k] = attr_q[k];
      if (cfg_addr == CFG_AW'(ATTR_BASE + k)) attr_d[k] = cfg_wdata;
    end
    for (int k = 0; k < NSMR; k++) begin
      smr_d[k] = smr_q[k];
      if (cfg_addr == CFG_AW'(SMR_BASE + k)) smr_d[k] = cfg_wdata;
    end
  end

  // registers, enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NATTR; k++) attr_q[k] <= 8'h00;
      for (int k = 0; k < NSMR; k++)  smr_q[k]  <= SMR_RESET[8*k +: 8];
    end else if (cfg_we) begin
      for (int k = 0; k < NATTR; k++) attr_q[k] <= attr_d[k];
      for (int k = 0; k < NSMR; k++)  smr_q[k]  <= smr_d[k];
    end
  end

  // read mux: unmapped offsets return zero
  always_comb begin
    cfg_rdata = 8'h00;
    for (int k = 0; k < NATTR; k++)
      if (cfg_addr == CFG_AW'(ATTR_BASE + k)) cfg_rdata = attr_q[k];
    for (int k = 0; k < NSMR; k++)
      if (cfg_addr == CFG_AW'(SMR_BASE + k)) cfg_rdata = smr_q[k];
  end

  // unpack two attribute fields per byte
  for (genvar i = 0; i < NSEG; i++) begin : g_attr
    assign attr_vec[2*i +: 2] = attr_q[i/2][(i%2)*4 +: 2];
  end

  assign smram = {smr_q[3], smr_q[2], smr_q[1], smr_q[0]};

  // R10: a write to a mapped byte is visible on readback after the edge
  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CFG_AW'(ATTR_BASE)) |=> (attr_q[0] == $past(cfg_wdata)));
endmodule

// File: rtl/lwr_seg_decode.sv
module lwr_seg_decode
  import lwr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output logic [SEG_W-1:0]  seg_idx
);
  logic [32:0] a33;
  logic [32:0] off;

  assign a33 = 33'(addr);
  assign off = a33 - MID_LO;

  always_comb begin
    in_win = (a33 >= WIN_LO) && (a33 < WIN_HI);
    if (a33 < MID_LO)      seg_idx = '0;
    else if (a33 < TOP_LO) seg_idx = SEG_W'(off[17:14]) + SEG_W'(1);
    else                   seg_idx = SEG_W'(NSEG - 1);
  end
endmodule

// File: rtl/lwr_smram_check.sv
module lwr_smram_check
  import lwr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [31:0]       smram,
  input  logic              smm,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [32:0] base;
  logic [32:0] size;
  logic [32:0] lim;
  logic [32:0] a33;
  logic        open_w;
  logic        fits;

  always_comb begin
    a33    = 33'(addr);
    base   = {1'b0, smram[15:0], 16'h0000};
    size   = (33'(smram[23:20]) + 33'd1) << 16;
    lim    = base + size;
    open_w = (smram[31] && smm) || smram[26];
    fits   = (base >= WIN_LO) && (lim <= WIN_HI);
    hit    = open_w && fits && (a33 >= base) && (a33 < lim);
  end
endmodule

// File: rtl/legacy_window_router.sv
module legacy_window_router
  import lwr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              smm_mode,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              rt_valid,
  output logic              rt_dram,
  output logic              rt_legacy,
  output logic              rt_wr_drop
);
  logic rst_meta, rst_int_n;
  logic smm_q;
  logic [2*NSEG-1:0] attr_vec;
  logic [31:0]       smram;
  logic              in_win, win_hit;
  logic [SEG_W-1:0]  seg_idx;
  attr_e             attr;
  logic              valid_d, dram_d, legacy_d, drop_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_int_n, rst_meta} <= 2'b00;
    else        {rst_int_n, rst_meta} <= {rst_meta, 1'b1};
  end

  lwr_cfg_regs #(.CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .attr_vec(attr_vec), .smram(smram)
  );

  lwr_seg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(acc_addr), .in_win(in_win), .seg_idx(seg_idx)
  );

  lwr_smram_check #(.ADDR_W(ADDR_W)) u_smr (
    .smram(smram), .smm(smm_q), .addr(acc_addr), .hit(win_hit)
  );

  // route next state
  always_comb begin
    attr     = attr_e'(attr_vec[2*seg_idx +: 2]);
    valid_d  = acc_valid;
    dram_d   = 1'b0;
    legacy_d = 1'b0;
    drop_d   = 1'b0;
    if (acc_valid) begin
      if (!in_win || win_hit) begin
        dram_d = 1'b1;
      end else begin
        unique case (attr)
          ATTR_RW: dram_d = 1'b1;
          ATTR_RO: begin
            drop_d = acc_write;
            dram_d = !acc_write;
          end
          default: legacy_d = 1'b1;
        endcase
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      smm_q      <= 1'b0;
      rt_valid   <= 1'b0;
      rt_dram    <= 1'b0;
      rt_legacy  <= 1'b0;
      rt_wr_drop <= 1'b0;
    end else begin
      smm_q      <= smm_mode;
      rt_valid   <= valid_d;
      rt_dram    <= dram_d;
      rt_legacy  <= legacy_d;
      rt_wr_drop <= drop_d;
    end
  end

  // R11: one decision per sampled access, one cycle later
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_valid |=> rt_valid);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !acc_valid |=> !rt_valid);
  // R3: exactly one destination while valid, none otherwise
  a_r3_one_route: assert property (@(posedge clk) disable iff (!rst_int_n)
    rt_valid |-> ($countones({rt_dram, rt_legacy, rt_wr_drop}) == 1));
  a_r3_none_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rt_valid |-> !(rt_dram || rt_legacy || rt_wr_drop));
  // R3: only writes are ever dropped
  a_r3_drop_is_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_valid && !acc_write) |=> !rt_wr_drop);
  // R5: outside the legacy region always DRAM
  a_r5_outside_dram: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_valid && !in_win) |=> rt_dram);
  // R8: window hit overrides any attribute
  a_r8_window_dram: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_valid && win_hit) |=> rt_dram);
endmodule

// File: tb/test_legacy_window_router.sv
module test_legacy_window_router;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        smm_mode;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic        acc_write;
  logic        rt_valid, rt_dram, rt_legacy, rt_wr_drop;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0]  sh_attr [7];
  logic [31:0] sh_smr;
  logic        sh_smm;

  always #10 clk = ~clk;

  legacy_window_router i_legacy_window_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smm_mode(smm_mode),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
    .rt_valid(rt_valid), .rt_dram(rt_dram), .rt_legacy(rt_legacy),
    .rt_wr_drop(rt_wr_drop)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected {valid, dram, legacy, drop}
  function automatic logic [3:0] model(input logic [31:0] a, input logic w);
    longint al, base, size;
    int seg;
    logic [1:0] at;
    bit hit;
    al = longint'(a);
    if (al < 'hA0000 || al >= 'h100000) return 4'b1100;
    if (al < 'hC0000) seg = 0;
    else if (al < 'hF0000) seg = 1 + int'((al - 'hC0000) / 'h4000);
    else seg = 13;
    at   = sh_attr[seg/2][(seg%2)*4 +: 2];
    base = longint'(sh_smr[15:0]) * 'h10000;
    size = (longint'(sh_smr[23:20]) + 1) * 'h10000;
    hit  = ((sh_smr[31] && sh_smm) || sh_smr[26]) && base >= 'hA0000 &&
           (base + size) <= 'h100000 && al >= base && al < base + size;
    if (hit || at == 2'd3) return 4'b1100;
    if (at == 2'd2) return w ? 4'b1001 : 4'b1100;
    return 4'b1010;
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a >= 8'h61 && a <= 8'h67) sh_attr[a - 8'h61] = d;
    if (a >= 8'h6C && a <= 8'h6F) sh_smr[8*(a - 8'h6C) +: 8] = d;
  endtask

  task automatic set_smr(input logic [31:0] v);
    for (int k = 0; k < 4; k++) cfg_write(8'h6C + 8'(k), v[8*k +: 8]);
  endtask

  task automatic set_smm(input logic v);
    smm_mode = v;
    @(negedge clk);
    sh_smm = v;
  endtask

  task automatic access(input string req, input logic [31:0] a, input logic w);
    logic [3:0] exp;
    exp = model(a, w);
    acc_valid = 1'b1; acc_addr = a; acc_write = w;
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, {28'h0, rt_valid, rt_dram, rt_legacy, rt_wr_drop}, {28'h0, exp});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seg_lo [14];
    logic [31:0] seg_hi [14];
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    smm_mode = 1'b0; acc_valid = 1'b0; acc_addr = '0; acc_write = 1'b0;
    for (int k = 0; k < 7; k++) sh_attr[k] = 8'h00;
    sh_smr = 32'h0000000A; sh_smm = 1'b0;
    for (int i = 0; i < 14; i++) begin
      if (i == 0) begin seg_lo[i] = 32'hA0000; seg_hi[i] = 32'hBFFFF; end
      else if (i == 13) begin seg_lo[i] = 32'hF0000; seg_hi[i] = 32'hFFFFF; end
      else begin
        seg_lo[i] = 32'hC0000 + 32'(i - 1) * 32'h4000;
        seg_hi[i] = seg_lo[i] + 32'h3FFF;
      end
    end
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 outputs in reset", {28'h0, rt_valid, rt_dram, rt_legacy, rt_wr_drop}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R6: reset values of the configuration space
    for (int a = 0; a < 256; a++) begin
      cfg_addr = 8'(a); #1;
      if (a >= 'h61 && a <= 'h67) check("R6 attr reset", 32'(cfg_rdata), 32'h00);
      else if (a >= 'h6C && a <= 'h6F) check("R6 smram reset", 32'(cfg_rdata), 32'(8'(32'h0A >> (8*(a - 'h6C)))));
      else check("R10 unmapped reads zero", 32'(cfg_rdata), 32'h00);
    end
    @(negedge clk);
    // R12/R4: reset attributes send the region to the legacy bus
    access("R12 reset route", 32'hC8000, 1'b0);
    // R11: idle cycle gives no decision
    @(negedge clk);
    check("R11 idle quiet", {28'h0, rt_valid, rt_dram, rt_legacy, rt_wr_drop}, 32'h0);

    // R10: write every offset, mapped bytes keep it, unmapped read zero
    for (int a = 0; a < 256; a++) cfg_write(8'(a), 8'(a) ^ 8'h5A);
    for (int a = 0; a < 256; a++) begin
      cfg_addr = 8'(a); #1;
      if ((a >= 'h61 && a <= 'h67) || (a >= 'h6C && a <= 'h6F))
        check("R10 mapped readback", 32'(cfg_rdata), 32'(8'(a) ^ 8'h5A));
      else check("R10 unmapped write ignored", 32'(cfg_rdata), 32'h00);
    end
    @(negedge clk);
    set_smr(32'h0000000A);

    // R1..R4: rotate attributes over segments, junk in unused bits
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < 7; b++) begin
        logic [1:0] lo, hi;
        lo = 2'((2*b + p) & 3);
        hi = 2'((2*b + 1 + p) & 3);
        cfg_write(8'h61 + 8'(b), (p % 2 == 1) ? {2'b11, hi, 2'b11, lo} : {2'b00, hi, 2'b00, lo});
      end
      for (int i = 0; i < 14; i++) begin
        access("R1 R2 R3 R4 segment low read", seg_lo[i], 1'b0);
        access("R1 R2 R3 R4 segment low write", seg_lo[i], 1'b1);
        access("R1 R2 R3 R4 segment high read", seg_hi[i], 1'b0);
        access("R1 R2 R3 R4 segment high write", seg_hi[i], 1'b1);
      end
    end

    // R5: outside the region
    for (int b = 0; b < 7; b++) cfg_write(8'h61 + 8'(b), 8'h00);
    access("R5 below region", 32'h9FFFF, 1'b1);
    access("R5 above region", 32'h100000, 1'b0);
    access("R5 zero", 32'h0, 1'b1);
    access("R5 top", 32'hFFFFFFFF, 1'b0);
    access("R4 first byte", 32'hA0000, 1'b1);

    // R7 R8 R9: window sweep over read-only segments
    for (int b = 0; b < 7; b++) cfg_write(8'h61 + 8'(b), 8'h22);
    for (int c = 0; c < 4; c++) begin
      set_smm((c == 1 || c == 3) ? 1'b1 : 1'b0);
      for (int bf = 8; bf <= 16; bf++) begin
        for (int si = 0; si < 4; si++) begin
          logic [3:0]  sz;
          logic [31:0] ctl, base, lim;
          sz   = (si == 0) ? 4'd0 : (si == 1) ? 4'd1 : (si == 2) ? 4'd3 : 4'd5;
          ctl  = (c == 0) ? 32'h0400_0000 : (c == 3) ? 32'h0 : 32'h8000_0000;
          set_smr(ctl | {8'h00, sz, 4'h0, 16'(bf)});
          base = 32'(bf) << 16;
          lim  = base + ((32'(sz) + 1) << 16);
          for (int k = 0; k < 24; k++)
            access("R7 R8 R9 window probe", 32'hA0000 + 32'(k) * 32'h4000 + 32'h10, k[0]);
          access("R8 R9 below base", base - 1, 1'b1);
          access("R8 R9 at base", base, 1'b1);
          access("R8 R9 last byte", lim - 1, 1'b1);
          access("R8 R9 past end", lim, 1'b1);
        end
      end
    end

    // R11: mode change on the same edge as an access is not yet seen
    set_smm(1'b0);
    set_smr(32'h8000_000C);
    smm_mode = 1'b1;
    access("R11 mode change lags one edge", 32'hC0000, 1'b1);
    sh_smm = 1'b1;
    access("R11 mode change seen next", 32'hC0000, 1'b1);
    smm_mode = 1'b0;
    access("R11 mode drop lags one edge", 32'hC0000, 1'b1);
    sh_smm = 1'b0;
    access("R11 mode drop seen next", 32'hC0000, 1'b1);

    // R10: attribute write seen by the immediately following access
    cfg_write(8'h67, 8'h03);
    access("R10 next access sees write", 32'hF8000, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule